// File: doc/BRIEF.md
# Signed Array Multiplier with Folded Sign Correction

This block multiplies two N-bit two's complement operands and returns their 2N-bit two's complement product. It is a purely combinational array. Every partial-product bit comes from a single AND gate. The sign is handled without extending any row to full width. The cross terms that pair one sign bit with one ordinary bit are inverted. The sign-by-sign term keeps its true polarity. Two fixed ones are pre-loaded into the accumulation, at bit N and at bit 2N-1. Because of this, the array of adders is about the same size as one for unsigned operands.

Accumulation starts from the constant word. It then runs through N ripple rows, and each row adds one partial-product row shifted by its index. The combinational product is available on `prod`. A one-stage output register follows it and is enabled by `op_valid`. That register drives `prod_q` and a matching `prod_q_valid` flag, for use where the product must be timed to a clock edge.

Top module: `bw_signed_mult`

## Requirements
- R1: For every pair of operands, `prod` equals x times y modulo 2^(2N). Bit N-1 of each operand carries weight -2^(N-1), and every other bit i carries weight +2^i.
- R2: The product of the two most negative operands is +2^(2N-2) and fits in 2N bits. For N=4, -8 × -8 gives 8'h40.
- R3: The most negative operand times the most positive gives the correct negative result. For N=4, -8 × 7 gives -56 = 8'hC8, and 7 × -8 also gives 8'hC8.
- R4: If either operand is zero, `prod` is all zeros.
- R5: On a rising clock edge with `op_valid` high, `prod_q` loads the current `prod`, and `prod_q_valid` is high after that edge.
- R6: On a rising clock edge with `op_valid` low, `prod_q` keeps its previous value, and `prod_q_valid` is low after that edge.
- R7: While `rst_n` is low, `prod_q` is zero and `prod_q_valid` is low.
- R8: `prod` follows a change on `x` or `y` within the same clock period, with no clock edge needed.
- R9: Multiplying by +1 returns the other operand sign-extended to 2N bits. Multiplying by -1 (all ones) returns its two's complement negation modulo 2^(2N).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Enables capture of the product on the next rising edge |
| x | input | N | Multiplicand, two's complement |
| y | input | N | Multiplier, two's complement |
| prod | output | 2N | Combinational product, two's complement |
| prod_q | output | 2N | Registered product |
| prod_q_valid | output | 1 | High for the cycle after a capture |

## Verification
For N=4 the bench sweeps all 256 operand pairs, and for N=8 it uses random pairs plus the sign extremes. A design that inverted the sign-by-sign term, or misplaced one of the two correction ones, would be off by a power of two. That error would show up at -8 × -8 and in every mixed-sign case. The zero and ±1 operands catch a wrong inversion rule, which would leave stray high bits where the result should be zero or a plain sign extension. Along the sweep, `op_valid` switches between cycles. This exposes an output register that loads when it should hold, or a flag that does not drop.

// File: rtl/bw_pkg.sv
package bw_pkg;

    // True when partial-product bit (i, j) pairs exactly one sign bit
    // with one ordinary bit; such bits are inverted.
    function automatic logic bw_invert(input int i, input int j, input int n);
        return ((i == n - 1) != (j == n - 1));
    endfunction

endpackage

// File: rtl/bw_pp_matrix.sv
module bw_pp_matrix #(
    parameter int N = 4
) (
    input  logic [N-1:0]   x,
    input  logic [N-1:0]   y,
    output logic [N*N-1:0] pp_flat
);
    import bw_pkg::*;

    // Row j occupies pp_flat[j*N +: N]; bit i of that row is x[i] & y[j].
    for (genvar j = 0; j < N; j++) begin : g_row
        for (genvar i = 0; i < N; i++) begin : g_col
            if (bw_invert(i, j, N)) begin : g_inv
                assign pp_flat[j*N + i] = ~(x[i] & y[j]);
            end else begin : g_true
                assign pp_flat[j*N + i] = x[i] & y[j];
            end
        end
    end
endmodule

// File: rtl/bw_fa.sv
module bw_fa (
    input  logic a,
    input  logic b,
    input  logic ci,
    output logic s,
    output logic co
);
    assign s  = a ^ b ^ ci;
    assign co = (a & b) | (ci & (a ^ b));
endmodule

// File: rtl/bw_add_row.sv
module bw_add_row #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] s
);
    logic [W-1:0] c;

    assign c[0] = 1'b0;

    for (genvar k = 0; k < W - 1; k++) begin : g_cell
        bw_fa u_fa (
            .a  (a[k]),
            .b  (b[k]),
            .ci (c[k]),
            .s  (s[k]),
            .co (c[k+1])
        );
    end

    // Top column: the carry out is dropped (result is modulo 2^W).
    assign s[W-1] = a[W-1] ^ b[W-1] ^ c[W-1];
endmodule

// File: rtl/bw_signed_mult.sv
module bw_signed_mult #(
    parameter int N       = 4,
    parameter bit REG_OUT = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           op_valid,
    input  logic [N-1:0]   x,
    input  logic [N-1:0]   y,
    output logic [2*N-1:0] prod,
    output logic [2*N-1:0] prod_q,
    output logic           prod_q_valid
);
    localparam int W = 2 * N;
    localparam logic [W-1:0] K_CORR = (W'(1) << N) | (W'(1) << (W - 1));

    logic [N*N-1:0] pp_flat;
    logic [W-1:0]   acc    [N+1];
    logic [W-1:0]   addend [N];

    bw_pp_matrix #(.N(N)) u_pp (
        .x       (x),
        .y       (y),
        .pp_flat (pp_flat)
    );

    assign acc[0] = K_CORR;

    for (genvar j = 0; j < N; j++) begin : g_acc
        assign addend[j] = W'(pp_flat[j*N +: N]) << j;
        bw_add_row #(.W(W)) u_row (
            .a (acc[j]),
            .b (addend[j]),
            .s (acc[j+1])
        );
    end

    assign prod = acc[N];

    // Behavioural reference used only by the property below.
    logic [W-1:0] ref_prod;
    assign ref_prod = W'(W'($signed(x)) * W'($signed(y)));

    a_r1_signed_product: assert property (@(posedge clk) disable iff (!rst_n)
        prod == ref_prod);

    a_r4_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
        ((x == '0) || (y == '0)) |-> (prod == '0));

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prod_q       <= '0;
                prod_q_valid <= 1'b0;
            end else begin
                prod_q_valid <= op_valid;
                if (op_valid) begin
                    prod_q <= prod;
                end
            end
        end

        a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
            op_valid |=> (prod_q_valid && prod_q == $past(prod)));

        a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !op_valid |=> (!prod_q_valid && $stable(prod_q)));

        always_comb begin
            if (!rst_n) begin
                a_r7_reset_clear: assert (prod_q == '0 && !prod_q_valid);
            end
        end
    end else begin : g_pass
        assign prod_q       = prod;
        assign prod_q_valid = op_valid;
    end
endmodule

// File: tb/bw_signed_mult_test.sv
module bw_signed_mult_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;

    logic       v4 = 1'b0;
    logic [3:0] x4 = '0, y4 = '0;
    logic [7:0] p4, pq4;
    logic       pv4;

    logic       v8 = 1'b0;
    logic [7:0] x8 = '0, y8 = '0;
    logic [15:0] p8, pq8;
    logic        pv8;

    bw_signed_mult #(.N(4)) uut (
        .clk(clk), .rst_n(rst_n), .op_valid(v4), .x(x4), .y(y4),
        .prod(p4), .prod_q(pq4), .prod_q_valid(pv4)
    );

    bw_signed_mult #(.N(8)) uut8 (
        .clk(clk), .rst_n(rst_n), .op_valid(v8), .x(x8), .y(y8),
        .prod(p8), .prod_q(pq8), .prod_q_valid(pv8)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [15:0] sprod(input int a, input int b, input int n);
        int sa = (a >= (1 << (n - 1))) ? a - (1 << n) : a;
        int sb = (b >= (1 << (n - 1))) ? b - (1 << n) : b;
        int p  = sa * sb;
        return 16'(p & ((1 << (2 * n)) - 1));
    endfunction

    logic [7:0]  exp_q4 = '0;
    logic        exp_v4 = 1'b0;
    logic [15:0] exp_q8 = '0;
    logic        exp_v8 = 1'b0;

    task automatic apply4(input int a, input int b, input logic v, input string tag);
        logic [7:0] e;
        @(negedge clk);
        chk(exp_v4 ? "R5 n4 prod_q" : "R6 n4 prod_q", 16'(pq4), 16'(exp_q4));
        chk(exp_v4 ? "R5 n4 valid" : "R6 n4 valid", 16'(pv4), 16'(exp_v4));
        x4 = a[3:0]; y4 = b[3:0]; v4 = v;
        #5;
        e = 8'(sprod(a, b, 4));
        chk({tag, "/R8 n4 prod"}, 16'(p4), 16'(e));
        if (v) exp_q4 = e;
        exp_v4 = v;
    endtask

    task automatic apply8(input int a, input int b, input logic v, input string tag);
        logic [15:0] e;
        @(negedge clk);
        chk(exp_v8 ? "R5 n8 prod_q" : "R6 n8 prod_q", pq8, exp_q8);
        chk(exp_v8 ? "R5 n8 valid" : "R6 n8 valid", 16'(pv8), 16'(exp_v8));
        x8 = a[7:0]; y8 = b[7:0]; v8 = v;
        #5;
        e = sprod(a, b, 8);
        chk({tag, " n8 prod"}, p8, e);
        if (v) exp_q8 = e;
        exp_v8 = v;
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        n_cmp++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        string tag;
        // R7: outputs cleared while reset is held, even with a capture request
        v4 = 1'b1; v8 = 1'b1; x4 = 4'h5; y4 = 4'h3; x8 = 8'h11; y8 = 8'h22;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R7 n4 prod_q", 16'(pq4), 16'h0);
        chk("R7 n4 valid", 16'(pv4), 16'h0);
        chk("R7 n8 prod_q", pq8, 16'h0);
        chk("R7 n8 valid", 16'(pv8), 16'h0);
        v4 = 1'b0; v8 = 1'b0;
        rst_n = 1'b1;

        // R2, R3 named corners with fixed encodings
        apply4(8, 8, 1'b1, "R2");
        chk("R2 -8*-8", 16'(p4), 16'h0040);
        apply4(8, 7, 1'b1, "R3");
        chk("R3 -8*7", 16'(p4), 16'h00C8);
        apply4(7, 8, 1'b0, "R3");
        chk("R3 7*-8", 16'(p4), 16'h00C8);

        // Exhaustive sweep for N=4, with valid toggling
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                if (a == 0 || b == 0) tag = "R4";
                else if (a == 1 || b == 1 || a == 15 || b == 15) tag = "R9";
                else tag = "R1";
                apply4(a, b, ((a + b) % 3) != 0, tag);
            end
        end
        apply4(0, 0, 1'b0, "R4");

        // N=8 corners
        apply8(128, 128, 1'b1, "R2");
        chk("R2 n8 -128*-128", p8, 16'h4000);
        apply8(128, 127, 1'b1, "R3");
        apply8(127, 128, 1'b0, "R3");
        apply8(0, 200, 1'b1, "R4");
        apply8(173, 0, 1'b0, "R4");
        apply8(1, 200, 1'b1, "R9");
        apply8(255, 77, 1'b1, "R9");
        apply8(255, 128, 1'b0, "R9");

        // N=8 random pairs
        for (int k = 0; k < 3000; k++) begin
            int a = int'($urandom_range(0, 255));
            int b = int'($urandom_range(0, 255));
            apply8(a, b, k[0] ^ k[2], "R1");
        end
        apply8(0, 0, 1'b0, "R4");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule